// File: doc/BRIEF.md
# PS/2 Host Frame Receiver

This block receives the frames a PS/2 keyboard or mouse sends to the host. The open-drain clock and data lines enter asynchronously. Each line passes through a two-flop synchronizer and a short glitch filter. The filtered data line is sampled on every falling edge of the filtered PS/2 clock. An 11-bit frame is assembled and its start, parity and stop bits are checked. Each accepted byte is delivered with a one-cycle strobe.

The receiver times the gap between PS/2 clock falls in system clock cycles. A partial frame is dropped when the device goes quiet for too long or skips a clock. Faults fall into two classes. Silent faults drop the frame and do nothing more. Retry faults also raise a one-cycle request asking the transmit side to send the resend command (0xFE). A retry counter limits how many of these requests are raised back to back. While the host's own transmitter owns the bus, it holds the receiver idle. It can also abort a partial frame for one cycle.

The state machine has four states. IDLE waits for a start bit. DATA collects eight data bits. PARITY checks the odd-parity bit. STOP checks the stop bit. These are the named transitions:
- IDLE→DATA on a start bit of 0.
- DATA→DATA on each of the first seven data bits.
- DATA→PARITY on the eighth data bit.
- PARITY→STOP on a correct parity bit.
- STOP→IDLE on completion or stop error.
- PARITY→IDLE on parity error.
- any→IDLE on gap abort, timeout abort, hold or abort.

Top module: `ps2_frame_rx`

## Requirements
- R1: A frame consists of eleven PS/2 clock falls. The first carries a start bit of 0, the next eight carry the data byte with bit 0 first, then comes the parity bit, then a stop bit of 1. A frame that passes every check raises `byte_valid_o` for exactly one cycle, and `byte_o` holds the byte in that cycle.
- R2: The parity bit must be 1 when the data byte holds an even number of ones and 0 when it holds an odd number. A mismatch drops the frame and is a retry fault.
- R3: A fall that samples 1 while waiting for a start bit is discarded. The receiver stays in IDLE and raises no resend request.
- R4: A stop bit sampled as 0 drops the frame without a byte strobe and is a retry fault.
- R5: Once a frame has begun, TMO_CYC system cycles after the last accepted fall with no new fall drop the frame. The frame position counts 1 after the start bit and adds 1 per data bit, reaching 9 after the eighth data bit and 10 after parity. When the timeout hits at position QUIET_POS or below, it is a silent fault. Later, it is a retry fault.
- R6: Inside a frame, a fall that comes more than GAP_CYC cycles after the previous fall counts as a missed clock. The fall is discarded, the frame is dropped, and it is a retry fault.
- R7: On a retry fault, `resend_req_o` pulses for one cycle if fewer than RETRY_MAX requests have been raised since the counter last cleared, and the counter then increments. Otherwise no request is raised and the counter clears. An accepted byte also clears the counter.
- R8: While `hold_i` or `abort_i` is high, the receiver returns to IDLE, drops the partial byte and ignores PS/2 clock falls. It raises neither strobe nor request in the following cycle.
- R9: A line level shorter than FILTER_LEN system cycles is ignored. If the PS/2 clock pin is low before rising edge n of `clk_i` and stays low, the outputs for that fall change at edge n+FILTER_LEN+2.
- R10: While `rst_ni` is low, `byte_valid_o` and `resend_req_o` are 0 and `byte_o` is 0.
- R11: `byte_valid_o` and `resend_req_o` are never high in the same cycle, and each is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ps2_clk_i | input | 1 | PS/2 clock line level, asynchronous |
| ps2_dat_i | input | 1 | PS/2 data line level, asynchronous |
| hold_i | input | 1 | Host transmitter owns the bus; keep idle |
| abort_i | input | 1 | Drop any partial frame |
| byte_valid_o | output | 1 | One-cycle strobe for a received byte |
| byte_o | output | DATA_W | Received byte, valid with the strobe |
| resend_req_o | output | 1 | One-cycle request to send the resend command |

## Verification
Some properties are checked on every cycle:
- Strobe and request stay exclusive, single-cycle pulses.
- A rejected start bit leaves the receiver in IDLE with no request.
- A bad stop bit never yields a byte.
- A timeout always returns the machine to IDLE, and raises no request at an early position.
- Hold and abort force IDLE.
- Every request follows a retry fault, and no run of requests exceeds the retry limit.

Only the bench's scenarios can show the rest. That covers:
- the exact byte value and bit order;
- the cycle at which each strobe and request appears after a PS/2 fall;
- the parity rule over several byte patterns;
- the missed-clock rule and its later resynchronization;
- glitch rejection;
- how the retry count wraps over a sequence of bad frames.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;

    // Receive state machine positions.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DATA   = 2'd1,
        ST_PARITY = 2'd2,
        ST_STOP   = 2'd3
    } rx_state_e;

endpackage

// File: rtl/ps2rx_line_filt.sv
// Two-flop synchronizer followed by a stability filter. The filtered
// level follows the synchronized level only after it has differed for
// FILT_LEN consecutive system clocks.
module ps2rx_line_filt #(
    parameter int FILT_LEN = 4,
    parameter bit IDLE_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

    logic          meta_q;
    logic          sync_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            meta_q <= IDLE_VAL;
            sync_q <= IDLE_VAL;
        end else begin
            meta_q <= line_i;
            sync_q <= meta_q;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            line_o <= IDLE_VAL;
        end else if (sync_q == line_o) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q  <= '0;
            line_o <= sync_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ps2rx_gap_timer.sv
// Counts system cycles since the last PS/2 clock fall while a frame runs.
module ps2rx_gap_timer #(
    parameter int GAP_CYC = 10000,
    parameter int TMO_CYC = 15000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic run_i,
    output logic gap_over_o,
    output logic tmo_o
);
    localparam int CW = $clog2(TMO_CYC + 1);
    localparam logic [CW-1:0] TMO_LAST = CW'(TMO_CYC - 1);
    localparam logic [CW-1:0] GAP_LIM  = CW'(GAP_CYC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (run_i && (cnt_q != TMO_LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign gap_over_o = (cnt_q >= GAP_LIM);
    assign tmo_o      = (cnt_q == TMO_LAST);
endmodule

// File: rtl/ps2rx_retry.sv
// Bounded resend request generator.
module ps2rx_retry #(
    parameter int RETRY_MAX = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fail_i,
    input  logic good_i,
    output logic req_o
);
    localparam int CW = $clog2(RETRY_MAX + 1);
    localparam logic [CW-1:0] LIM = CW'(RETRY_MAX);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            req_o <= 1'b0;
        end else begin
            req_o <= 1'b0;
            if (good_i) begin
                cnt_q <= '0;
            end else if (fail_i) begin
                if (cnt_q < LIM) begin
                    cnt_q <= cnt_q + 1'b1;
                    req_o <= 1'b1;
                end else begin
                    cnt_q <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
    import ps2rx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FILTER_LEN = 4,
    parameter int GAP_CYC    = 10000,
    parameter int TMO_CYC    = 15000,
    parameter int RETRY_MAX  = 3,
    parameter int QUIET_POS  = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ps2_clk_i,
    input  logic              ps2_dat_i,
    input  logic              hold_i,
    input  logic              abort_i,
    output logic              byte_valid_o,
    output logic [DATA_W-1:0] byte_o,
    output logic              resend_req_o
);
    localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IW-1:0] IDX_LAST = IW'(DATA_W - 1);
    localparam int N_LINES = 2;

    // Line conditioning: index 0 is the PS/2 clock, index 1 the data.
    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] filt_lines;
    assign raw_lines = {ps2_dat_i, ps2_clk_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        ps2rx_line_filt #(
            .FILT_LEN(FILTER_LEN),
            .IDLE_VAL(1'b1)
        ) u_filt (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .line_i(raw_lines[g]),
            .line_o(filt_lines[g])
        );
    end

    logic clk_f, dat_f, clk_d_q, fall;
    assign clk_f = filt_lines[0];
    assign dat_f = filt_lines[1];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) clk_d_q <= 1'b1;
        else         clk_d_q <= clk_f;
    end
    assign fall = clk_d_q & ~clk_f;

    // State and frame storage.
    rx_state_e          state_q, state_n;
    logic [IW-1:0]      idx_q, idx_n;
    logic [DATA_W-1:0]  sh_q, sh_n;
    logic               ev_good, ev_resend;
    logic               quiet_pos;
    logic               gap_over, tmo;
    logic               idle_force;

    assign idle_force = hold_i | abort_i;
    assign quiet_pos  = (state_q == ST_DATA) && ((int'(idx_q) + 1) <= QUIET_POS);

    ps2rx_gap_timer #(
        .GAP_CYC(GAP_CYC),
        .TMO_CYC(TMO_CYC)
    ) u_gap (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (fall | idle_force | (state_q == ST_IDLE)),
        .run_i     (state_q != ST_IDLE),
        .gap_over_o(gap_over),
        .tmo_o     (tmo)
    );

    always_comb begin
        state_n   = state_q;
        idx_n     = idx_q;
        sh_n      = sh_q;
        ev_good   = 1'b0;
        ev_resend = 1'b0;
        if (idle_force) begin
            state_n = ST_IDLE;
            idx_n   = '0;
            sh_n    = '0;
        end else if (fall) begin
            if ((state_q != ST_IDLE) && gap_over) begin
                ev_resend = 1'b1;
                state_n   = ST_IDLE;
                idx_n     = '0;
                sh_n      = '0;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (!dat_f) begin
                            state_n = ST_DATA;
                            idx_n   = '0;
                            sh_n    = '0;
                        end
                    end
                    ST_DATA: begin
                        sh_n = {dat_f, sh_q[DATA_W-1:1]};
                        if (idx_q == IDX_LAST) state_n = ST_PARITY;
                        else                   idx_n   = idx_q + 1'b1;
                    end
                    ST_PARITY: begin
                        if (dat_f == ~^sh_q) begin
                            state_n = ST_STOP;
                        end else begin
                            ev_resend = 1'b1;
                            state_n   = ST_IDLE;
                            idx_n     = '0;
                            sh_n      = '0;
                        end
                    end
                    ST_STOP: begin
                        if (dat_f) ev_good   = 1'b1;
                        else       ev_resend = 1'b1;
                        state_n = ST_IDLE;
                        idx_n   = '0;
                    end
                    default: state_n = ST_IDLE;
                endcase
            end
        end else if ((state_q != ST_IDLE) && tmo) begin
            ev_resend = ~quiet_pos;
            state_n   = ST_IDLE;
            idx_n     = '0;
            sh_n      = '0;
        end
    end

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            sh_q    <= '0;
        end else begin
            state_q <= state_n;
            idx_q   <= idx_n;
            sh_q    <= sh_n;
        end
    end

    // Output register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            byte_valid_o <= 1'b0;
            byte_o       <= '0;
        end else begin
            byte_valid_o <= ev_good;
            if (ev_good) byte_o <= sh_q;
        end
    end

    ps2rx_retry #(
        .RETRY_MAX(RETRY_MAX)
    ) u_retry (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .fail_i(ev_resend),
        .good_i(ev_good),
        .req_o (resend_req_o)
    );
endmodule

// File: rtl/ps2rx_checker.sv
module ps2rx_checker
    import ps2rx_pkg::*;
#(
    parameter int IW        = 3,
    parameter int RETRY_MAX = 3,
    parameter int QUIET_POS = 3
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          hold_i,
    input logic          abort_i,
    input logic          fall,
    input logic          dat_f,
    input logic          gap_over,
    input logic          tmo,
    input logic          ev_resend,
    input logic          byte_valid_o,
    input logic          resend_req_o,
    input rx_state_e     state_q,
    input logic [IW-1:0] idx_q
);
    logic quiet_chk;
    assign quiet_chk = (state_q == ST_DATA) && ((int'(idx_q) + 1) <= QUIET_POS);

    assert_single_valid_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        byte_valid_o |=> !byte_valid_o)
        else $error("byte strobe longer than one cycle");

    assert_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(byte_valid_o && resend_req_o))
        else $error("strobe and resend request together");

    assert_req_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        resend_req_o |=> !resend_req_o)
        else $error("resend request longer than one cycle");

    assert_start_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_IDLE && fall && dat_f && !hold_i && !abort_i)
        |=> (state_q == ST_IDLE && !resend_req_o))
        else $error("start bit of 1 was not discarded");

    assert_stop_bad_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_STOP && fall && !dat_f && !gap_over && !hold_i && !abort_i)
        |=> (state_q == ST_IDLE && !byte_valid_o))
        else $error("bad stop bit produced a byte");

    assert_timeout_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_IDLE && tmo && !fall && !hold_i && !abort_i) |=> (state_q == ST_IDLE))
        else $error("timeout did not drop the frame");

    assert_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (quiet_chk && tmo && !fall && !hold_i && !abort_i) |=> !resend_req_o)
        else $error("early timeout raised a resend request");

    assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hold_i || abort_i) |=> (state_q == ST_IDLE && !byte_valid_o && !resend_req_o))
        else $error("hold or abort did not force idle");

    assert_req_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        resend_req_o |-> $past(ev_resend))
        else $error("resend request without a retry fault");

    // Run of consecutive requests since a good byte or a suppressed fault.
    logic ev_d_q;
    int   run_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ev_d_q <= 1'b0;
            run_q  <= 0;
        end else begin
            ev_d_q <= ev_resend;
            if (byte_valid_o || (ev_d_q && !resend_req_o)) run_q <= 0;
            else if (resend_req_o)                         run_q <= run_q + 1;
        end
    end

    always @(posedge clk_i) begin
        if (rst_ni) begin
            assert_retry_bound_R7: assert (run_q <= RETRY_MAX)
                else $error("too many consecutive resend requests");
        end
    end
endmodule

bind ps2_frame_rx ps2rx_checker #(
    .IW       (IW),
    .RETRY_MAX(RETRY_MAX),
    .QUIET_POS(QUIET_POS)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hold_i      (hold_i),
    .abort_i     (abort_i),
    .fall        (fall),
    .dat_f       (dat_f),
    .gap_over    (gap_over),
    .tmo         (tmo),
    .ev_resend   (ev_resend),
    .byte_valid_o(byte_valid_o),
    .resend_req_o(resend_req_o),
    .state_q     (state_q),
    .idx_q       (idx_q)
);

// File: tb/tb_ps2_frame_rx.sv
module tb_ps2_frame_rx;
    localparam int F    = 2;
    localparam int GAP  = 45;
    localparam int TMO  = 70;
    localparam int RMAX = 3;
    localparam int QP   = 3;
    localparam int H    = 20;
    localparam int LAT  = F + 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic pclk = 1'b1, pdat = 1'b1, hold = 1'b0, abrt = 1'b0;
    logic       valid, resend;
    logic [7:0] byte_o;

    always #5 clk = ~clk;

    ps2_frame_rx #(
        .DATA_W(8), .FILTER_LEN(F), .GAP_CYC(GAP), .TMO_CYC(TMO),
        .RETRY_MAX(RMAX), .QUIET_POS(QP)
    ) dut (
        .clk_i(clk), .rst_ni(rst_n), .ps2_clk_i(pclk), .ps2_dat_i(pdat),
        .hold_i(hold), .abort_i(abrt), .byte_valid_o(valid), .byte_o(byte_o),
        .resend_req_o(resend)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic rst_s = 1'b0, hold_s = 1'b0, abrt_s = 1'b0;
    always @(posedge clk) begin
        rst_s  <= rst_n;
        hold_s <= hold;
        abrt_s <= abrt;
    end

    int n_run = 0, n_fail = 0, n_val = 0, n_rs = 0;
    string cur_req = "R10";

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Falls scheduled for the model: cycle at which the design acts.
    int q_act[$];
    bit q_bit[$];

    // Behavioural reference model.
    int         m_pos = 0, m_last = 0, m_retry = 0;
    logic [7:0] m_byte = '0, exp_b = '0;
    bit         m_fall, m_bit, ev_v, ev_r, res;

    always @(negedge clk) begin
        if (rst_s) begin
            m_fall = 0; ev_v = 0; ev_r = 0; res = 0; m_bit = 0;
            if (q_act.size() > 0 && q_act[0] == cyc) begin
                m_fall = 1;
                m_bit  = q_bit[0];
                void'(q_act.pop_front());
                void'(q_bit.pop_front());
            end
            if (hold_s || abrt_s) begin
                m_pos = 0; m_byte = '0;
            end else if (m_fall) begin
                if (m_pos > 0 && (cyc - m_last) > GAP) begin
                    res = 1;
                end else begin
                    case (m_pos)
                        0: if (!m_bit) begin m_pos = 1; m_byte = '0; end
                        9: if (m_bit == ~^m_byte) m_pos = 10; else res = 1;
                        10: begin
                            if (m_bit) begin ev_v = 1; exp_b = m_byte; m_retry = 0; end
                            else res = 1;
                            m_pos = 0;
                        end
                        default: begin m_byte[m_pos-1] = m_bit; m_pos++; end
                    endcase
                end
                m_last = cyc;
            end else if (m_pos > 0 && (cyc - m_last) == TMO) begin
                if (m_pos > QP) res = 1;
                m_pos = 0; m_byte = '0;
            end
            if (res) begin
                m_pos = 0; m_byte = '0;
                if (m_retry < RMAX) begin m_retry++; ev_r = 1; end
                else m_retry = 0;
            end
            chk(valid === ev_v, cur_req, "byte_valid_o", valid, ev_v);
            chk(resend === ev_r, cur_req, "resend_req_o", resend, ev_r);
            if (ev_v) chk(byte_o === exp_b, cur_req, "byte_o", byte_o, exp_b);
            chk(!(valid && resend), "R11", "strobe and request together", {valid, resend}, 0);
            if (valid)  n_val++;
            if (resend) n_rs++;
        end
    end

    task automatic bit_out(input bit b, input int extra);
        @(negedge clk);
        pdat = b;
        repeat (H + extra) @(negedge clk);
        pclk = 1'b0;
        q_act.push_back(cyc + LAT);
        q_bit.push_back(b);
        repeat (H) @(negedge clk);
        pclk = 1'b1;
    endtask

    task automatic idle_wait();
        @(negedge clk);
        pdat = 1'b1;
        repeat (TMO + 30) @(negedge clk);
    endtask

    task automatic frame(input logic [7:0] b, input bit par_bad, input bit stop_v,
                         input int nbits, input int gap_pos);
        bit bits[11];
        bits[0] = 1'b0;
        for (int i = 0; i < 8; i++) bits[i+1] = b[i];
        bits[9]  = (~^b) ^ par_bad;
        bits[10] = stop_v;
        for (int i = 0; i < nbits; i++) bit_out(bits[i], (i == gap_pos) ? 10 : 0);
        idle_wait();
    endtask

    int v0, r0;

    initial begin
        repeat (3) @(negedge clk);
        chk(valid === 1'b0, "R10", "byte_valid_o in reset", valid, 0);
        chk(resend === 1'b0, "R10", "resend_req_o in reset", resend, 0);
        chk(byte_o === 8'h00, "R10", "byte_o in reset", byte_o, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R1 / R2: good frames across parity patterns.
        cur_req = "R1"; v0 = n_val; r0 = n_rs;
        frame(8'hA5, 0, 1, 11, -1);
        frame(8'h00, 0, 1, 11, -1);
        frame(8'hFF, 0, 1, 11, -1);
        frame(8'h3C, 0, 1, 11, -1);
        frame(8'h01, 0, 1, 11, -1);
        chk(n_val - v0 == 5, "R1", "good byte count", n_val - v0, 5);
        chk(n_rs - r0 == 0, "R2", "no resend on good parity", n_rs - r0, 0);

        // R3: start bit of 1 discarded.
        cur_req = "R3"; v0 = n_val; r0 = n_rs;
        bit_out(1'b1, 0);
        idle_wait();
        chk(n_rs - r0 == 0, "R3", "resend after start=1", n_rs - r0, 0);
        frame(8'h96, 0, 1, 11, -1);
        chk(n_val - v0 == 1, "R3", "byte after start=1", n_val - v0, 1);

        // R2: parity error.
        cur_req = "R2"; v0 = n_val; r0 = n_rs;
        frame(8'h17, 1, 1, 11, -1);
        chk(n_rs - r0 == 1, "R2", "resend on parity error", n_rs - r0, 1);
        chk(n_val - v0 == 0, "R2", "no byte on parity error", n_val - v0, 0);
        frame(8'h6E, 0, 1, 11, -1);

        // R4: stop error.
        cur_req = "R4"; v0 = n_val; r0 = n_rs;
        frame(8'h42, 0, 0, 11, -1);
        chk(n_rs - r0 == 1, "R4", "resend on stop error", n_rs - r0, 1);
        chk(n_val - v0 == 0, "R4", "no byte on stop error", n_val - v0, 0);
        frame(8'h81, 0, 1, 11, -1);

        // R5: early and late timeouts.
        cur_req = "R5"; r0 = n_rs;
        frame(8'h33, 0, 1, 3, -1);
        chk(n_rs - r0 == 0, "R5", "resend on early timeout", n_rs - r0, 0);
        r0 = n_rs;
        frame(8'h33, 0, 1, 6, -1);
        chk(n_rs - r0 == 1, "R5", "resend on late timeout", n_rs - r0, 1);
        frame(8'hC3, 0, 1, 11, -1);

        // R6: missed clock at the fifth data bit.
        cur_req = "R6"; v0 = n_val; r0 = n_rs;
        frame(8'h5A, 0, 1, 11, 5);
        chk(n_rs - r0 == 2, "R6", "resends after missed clock", n_rs - r0, 2);
        chk(n_val - v0 == 0, "R6", "no byte after missed clock", n_val - v0, 0);
        frame(8'h24, 0, 1, 11, -1);

        // R9: glitches shorter than the filter.
        cur_req = "R9"; v0 = n_val; r0 = n_rs;
        @(negedge clk); pclk = 1'b0; @(negedge clk); pclk = 1'b1;
        @(negedge clk); pdat = 1'b0; @(negedge clk); pdat = 1'b1;
        idle_wait();
        chk((n_val - v0 == 0) && (n_rs - r0 == 0), "R9", "glitch activity", (n_val - v0) + (n_rs - r0), 0);
        frame(8'h7E, 0, 1, 11, -1);
        chk(n_val - v0 == 1, "R9", "byte after glitch", n_val - v0, 1);

        // R7: retry bound over consecutive bad frames.
        cur_req = "R7"; r0 = n_rs;
        for (int k = 0; k < 5; k++) frame(8'h10 + 8'(k), 1, 1, 11, -1);
        chk(n_rs - r0 == 4, "R7", "resend pulses over five faults", n_rs - r0, 4);
        frame(8'h55, 0, 1, 11, -1);
        r0 = n_rs;
        frame(8'h56, 1, 1, 11, -1);
        chk(n_rs - r0 == 1, "R7", "resend after good byte cleared count", n_rs - r0, 1);
        frame(8'h57, 0, 1, 11, -1);

        // R8: hold during a frame, then an abort pulse.
        cur_req = "R8"; v0 = n_val;
        fork
            frame(8'h81, 0, 1, 11, -1);
            begin
                repeat (150) @(negedge clk); hold = 1'b1;
                repeat (60) @(negedge clk);  hold = 1'b0;
            end
        join
        chk(n_val - v0 == 0, "R8", "byte despite hold", n_val - v0, 0);
        v0 = n_val;
        fork
            frame(8'h99, 0, 1, 11, -1);
            begin
                repeat (250) @(negedge clk); abrt = 1'b1;
                @(negedge clk); abrt = 1'b0;
            end
        join
        chk(n_val - v0 == 0, "R8", "byte despite abort", n_val - v0, 0);
        frame(8'hE7, 0, 1, 11, -1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule